// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes of a multiplexed external memory bus. One is an active-high address-latch strobe that tells external logic when to capture the low address byte. The other is an active-low program-read strobe that enables external program memory onto the bus. A machine cycle lasts twelve clock periods. It is divided into six states of two phases each, and the strobes are decoded from the position inside that cycle.

Three control inputs are sampled once per machine cycle, on the clock edge that ends the last phase: the external-program-fetch flag, the external data access request and the latch-disable configuration bit. These samples govern the whole next cycle. In a plain fetch cycle the address strobe fires twice and the program strobe fires twice. In a cycle that carries an external data transfer, the first address pulse and both program pulses are withheld, and a data-cycle indicator stays high for all twelve periods. When the latch-disable bit is set, the address strobe is silent except in fetch or data cycles.

Top module: `ext_bus_strobe_gen`

## Requirements
- R1: The cycle position runs 0 to 11 and restarts at 0. Position p is state p/2+1, phase p%2+1. With latch-disable clear and no data access, `ale_o` is high at positions 1, 2, 7 and 8 and low at all others, which gives two pulses every twelve clocks.
- R2: In a data cycle the address pulse at positions 1 and 2 is absent. The pulse at positions 7 and 8 still occurs.
- R3: In a cycle with the fetch flag set and no data access, `psen_n_o` is low at positions 3 to 5 and 9 to 11 and high elsewhere. It is never low while `ale_o` is high.
- R4: In a data cycle `psen_n_o` stays high for all twelve positions, whatever the fetch flag is.
- R5: In a cycle with the fetch flag clear, `psen_n_o` stays high for all twelve positions.
- R6: With latch-disable set and neither fetch nor data access, `ale_o` stays low for the whole cycle.
- R7: With latch-disable set, a fetch cycle gives the normal two address pulses and a data cycle gives its single pulse at positions 7 and 8.
- R8: `data_cycle_o` is high for exactly the twelve positions of a cycle whose data request was sampled high, and low in every other cycle.
- R9: The inputs are sampled only on the clock edge that leaves position 11. Values applied at any other position have no effect on the outputs.
- R10: `rst_n` is synchronous and active low. While it is low, `ale_o` is low, `psen_n_o` is high and `data_cycle_o` is low. The first cycle after release starts at position 0 with fetch, data access and latch-disable all treated as clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_fetch_i | input | 1 | Next cycle fetches from external program memory |
| xdata_req_i | input | 1 | Next cycle performs an external data access |
| ale_disable_i | input | 1 | Latch-disable configuration bit (reset value 0) |
| ale_o | output | 1 | Address-latch strobe, active high |
| psen_n_o | output | 1 | Program-read strobe, active low |
| data_cycle_o | output | 1 | High during a data-access machine cycle |

## Verification
The bench applies every ordered pair of the eight control combinations in back-to-back cycles. It drives the complement of the wanted combination at every position except the sampling edge, so a design that sampled its inputs continuously would pulse or go quiet in the wrong cycle. The checks also cover the following faults:
- Suppressing the wrong address pulse in a data cycle, or neither pulse, shows up at positions 1, 2, 7 and 8.
- Letting the program strobe through in a fetch-plus-data cycle shows up at positions 3 to 5 and 9 to 11.
- Letting latch-disable silence the strobe during a fetch or data cycle shows up on the address strobe.

A reset in the middle of a cycle, applied while the inputs are held at all-ones, checks that the block restarts at position 0 with the address strobe running freely.

// File: rtl/bus_strobe_pkg.sv
// Shared types for the external bus strobe generator.
// Assumes: one attribute set governs one whole machine cycle.
package bus_strobe_pkg;

    // Attributes captured at the machine-cycle boundary
    typedef struct packed {
        logic latch_off;   // free-running address strobe suppressed
        logic data;        // cycle carries an external data access
        logic fetch;       // cycle fetches from external program memory
    } cyc_attr_t;

endpackage

// File: rtl/bst_phase_counter.sv
// Machine-cycle position counter: counts 0..PHASES-1 and wraps.
// Assumes: PHASES is even (states of two phases each).
module bst_phase_counter #(
    parameter int PHASES = 12,
    parameter int PW     = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] phase_o,
    output logic          last_o
);
    localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

    // advance position, restart after the final phase
    always_ff @(posedge clk) begin
        if (!rst_n)              phase_o <= '0;
        else if (phase_o == LAST) phase_o <= '0;
        else                     phase_o <= phase_o + 1'b1;
    end

    // flag the final phase of the machine cycle
    always_comb last_o = (phase_o == LAST);

    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == LAST) |=> (phase_o == '0));
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != LAST) |=> (phase_o == $past(phase_o) + 1'b1));
endmodule

// File: rtl/bst_cycle_attr.sv
// Captures the per-cycle control inputs on the edge leaving the last phase.
// Assumes: load_i is high only during the final phase of a cycle.
module bst_cycle_attr
    import bus_strobe_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_i,
    input  logic      ext_fetch_i,
    input  logic      xdata_req_i,
    input  logic      ale_disable_i,
    output cyc_attr_t attr_o
);
    // hold the attributes for a whole cycle, refresh at the boundary
    always_ff @(posedge clk) begin
        if (!rst_n)      attr_o <= '0;
        else if (load_i) attr_o <= '{latch_off: ale_disable_i,
                                     data:      xdata_req_i,
                                     fetch:     ext_fetch_i};
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(attr_o));
endmodule

// File: rtl/bst_strobe_decode.sv
// Decodes the strobes from the cycle position and the cycle attributes.
// Assumes: WINDOWS pulses per machine cycle, evenly spaced.
module bst_strobe_decode
    import bus_strobe_pkg::*;
#(
    parameter int PHASES   = 12,
    parameter int PW       = $clog2(PHASES),
    parameter int WINDOWS  = 2,
    parameter int ALE_OFS  = 1,
    parameter int ALE_LEN  = 2,
    parameter int PSEN_OFS = 3,
    parameter int PSEN_LEN = 3
) (
    input  logic [PW-1:0] phase_i,
    input  cyc_attr_t     attr_i,
    output logic          ale_o,
    output logic          psen_n_o
);
    localparam int SPAN = PHASES / WINDOWS;

    logic [WINDOWS-1:0] ale_win;
    logic [WINDOWS-1:0] psen_win;
    logic [WINDOWS-1:0] ale_en;

    // one address window and one program window per half cycle
    for (genvar k = 0; k < WINDOWS; k++) begin : g_win
        localparam logic [PW-1:0] A_LO = PW'(SPAN * k + ALE_OFS);
        localparam logic [PW-1:0] A_HI = PW'(SPAN * k + ALE_OFS + ALE_LEN - 1);
        localparam logic [PW-1:0] P_LO = PW'(SPAN * k + PSEN_OFS);
        localparam logic [PW-1:0] P_HI = PW'(SPAN * k + PSEN_OFS + PSEN_LEN - 1);
        // position inside this pair of windows
        always_comb begin
            ale_win[k]  = (phase_i >= A_LO) && (phase_i <= A_HI);
            psen_win[k] = (phase_i >= P_LO) && (phase_i <= P_HI);
        end
        // which address windows may fire in this cycle
        if (k == 0) begin : g_first
            always_comb ale_en[k] = !attr_i.data && (!attr_i.latch_off || attr_i.fetch);
        end else begin : g_rest
            always_comb ale_en[k] = !attr_i.latch_off || attr_i.fetch || attr_i.data;
        end
    end

    // combine windows into the two strobes
    always_comb begin
        ale_o    = |(ale_win & ale_en);
        psen_n_o = !(attr_i.fetch && !attr_i.data && (|psen_win));
    end
endmodule

// File: rtl/ext_bus_strobe_gen.sv
// External bus strobe generator top: address-latch strobe, program-read
// strobe and data-cycle indicator on a twelve-period machine cycle.
// Assumes: control inputs are valid on the edge that ends the cycle.
module ext_bus_strobe_gen
    import bus_strobe_pkg::*;
#(
    parameter int PHASES = 12,
    parameter int PW     = $clog2(PHASES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_fetch_i,
    input  logic xdata_req_i,
    input  logic ale_disable_i,
    output logic ale_o,
    output logic psen_n_o,
    output logic data_cycle_o
);
    logic [PW-1:0] phase;
    logic          last;
    cyc_attr_t     attr;

    bst_phase_counter #(.PHASES(PHASES), .PW(PW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .phase_o(phase), .last_o(last));

    bst_cycle_attr u_attr (
        .clk(clk), .rst_n(rst_n), .load_i(last),
        .ext_fetch_i(ext_fetch_i), .xdata_req_i(xdata_req_i),
        .ale_disable_i(ale_disable_i), .attr_o(attr));

    bst_strobe_decode #(.PHASES(PHASES), .PW(PW)) u_dec (
        .phase_i(phase), .attr_i(attr), .ale_o(ale_o), .psen_n_o(psen_n_o));

    // expose the data-cycle flag for the whole cycle
    always_comb data_cycle_o = attr.data;

    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ale_o && !psen_n_o));
    p_psen_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        data_cycle_o |-> psen_n_o);
    p_first_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (data_cycle_o && phase == PW'(1)) |-> !ale_o);
    p_ale_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (attr.latch_off && !attr.fetch && !attr.data) |-> !ale_o);
    p_dc_whole_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != '0) |-> $stable(data_cycle_o));
    p_fetch_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !attr.fetch |-> psen_n_o);
endmodule

// File: tb/ext_bus_strobe_gen_tb.sv
module ext_bus_strobe_gen_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_fetch, xdata, ale_dis;
    logic ale, psen_n, dcyc;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 0;

    always #4 clk = ~clk;

    ext_bus_strobe_gen u_dut (
        .clk(clk), .rst_n(rst_n), .ext_fetch_i(ext_fetch), .xdata_req_i(xdata),
        .ale_disable_i(ale_dis), .ale_o(ale), .psen_n_o(psen_n), .data_cycle_o(dcyc));

    // reference position and attributes, from the requirements
    logic [3:0] m_idx;
    logic m_f, m_d, m_x;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_idx <= 0; m_f <= 0; m_d <= 0; m_x <= 0;
        end else begin
            m_idx <= (m_idx == 11) ? 4'd0 : m_idx + 4'd1;
            if (m_idx == 11) begin
                m_f <= ext_fetch; m_d <= xdata; m_x <= ale_dis;
            end
        end
    end

    task automatic cmp(input string tag, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s pos=%0d actual=%b expected=%b", tag, m_idx, act, exp);
        end
    endtask

    task automatic check_now();
        logic in_a, in_b, in_p, e_ale, e_psen;
        string sfx, t_ale, t_psen;
        in_a  = (m_idx == 1) || (m_idx == 2);
        in_b  = (m_idx == 7) || (m_idx == 8);
        in_p  = (m_idx >= 3 && m_idx <= 5) || (m_idx >= 9);
        e_ale = (in_a && !m_d && (!m_x || m_f)) || (in_b && (!m_x || m_f || m_d));
        e_psen = !(m_f && !m_d && in_p);
        sfx = ({ale_dis, xdata, ext_fetch} != {m_x, m_d, m_f}) ? " R9" : "";
        t_ale = (m_x && !m_f && !m_d) ? "R6 ale" : m_d ? "R2 ale" : m_x ? "R7 ale" : "R1 ale";
        t_psen = m_d ? "R4 psen_n" : !m_f ? "R5 psen_n" : "R3 psen_n";
        cmp({t_ale, sfx}, ale, e_ale);
        cmp({t_psen, sfx}, psen_n, e_psen);
        cmp({"R8 data_cycle", sfx}, dcyc, m_d);
    endtask

    task automatic reset_check();
        cmp("R10 ale", ale, 1'b0);
        cmp("R10 psen_n", psen_n, 1'b1);
        cmp("R10 data_cycle", dcyc, 1'b0);
    endtask

    // one clock: check, then drive the wanted value only at the sampling edge
    task automatic step(input logic [2:0] want);
        @(negedge clk);
        check_now();
        if (m_idx == 11) {ale_dis, xdata, ext_fetch} = want;
        else             {ale_dis, xdata, ext_fetch} = ~want;
    endtask

    task automatic run_cycle(input logic [2:0] want);
        repeat (12) step(want);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        {ale_dis, xdata, ext_fetch} = 3'b111;
        repeat (2) @(posedge clk);
        repeat (3) begin @(negedge clk); reset_check(); end   // R10 held reset
        rst_n = 1'b1;
        // R10 first cycle free-running despite inputs at ones; then every pair
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++) begin
                run_cycle(3'(a));
                run_cycle(3'(b));
            end
        // R10 reset in mid-cycle
        while (m_idx != 5) step(3'b011);
        {ale_dis, xdata, ext_fetch} = 3'b111;
        rst_n = 1'b0;
        repeat (2) begin @(negedge clk); reset_check(); end
        rst_n = 1'b1;
        run_cycle(3'b001);
        run_cycle(3'b101);
        run_cycle(3'b100);
        finish_run();
    end
endmodule